// File: doc/BRIEF.md
# Register-Array LIFO Stack with Occupancy Flags

This block is a last-in-first-out store kept in an internal array of registers. A stack pointer selects the top entry. Two registered flags report whether the stack can accept another word (full) or has one to give (empty). A data register holds the word most recently removed.

A push first advances the pointer and then writes the input word into the entry the pointer now selects. A pop first copies the selected entry into the data register and then moves the pointer back. Each accepted operation sets or clears the flags directly. The flags are not derived from a separate count.

The pointer rests at zero when the stack is empty, and entry zero is never written. With `DEPTH` entries in the array, the stack therefore holds at most `DEPTH-1` words: 63 with the default depth of 64. A request that cannot be served has no effect. A cycle that raises both requests at once also has no effect.

Top module: `reg_stack`

## Requirements
- R1: After reset, `empty_o` is 1, `full_o` is 0 and `dout_o` is 0.
- R2: A push request with `full_o` low stores `din_i` on the stack and leaves `empty_o` at 0 after the clock edge.
- R3: A pop request with `empty_o` low loads the most recently pushed word that has not yet been popped into `dout_o` at the clock edge, so words come back in reverse order of arrival.
- R4: `full_o` becomes 1 on the edge that accepts the push bringing the pointer to `DEPTH-1`. The stack then holds `DEPTH-1` words (63 by default).
- R5: `empty_o` becomes 1 on the edge that accepts the pop bringing the pointer back to zero. `empty_o` is 1 exactly when the pointer is zero.
- R6: A push while `full_o` is 1 is ignored. The flags stay the same, and the stored words come back unchanged on later pops.
- R7: A pop while `empty_o` is 1 is ignored. `dout_o` and both flags stay the same.
- R8: A cycle with push and pop both high performs neither. The flags and `dout_o` stay the same, and the next pop returns the same word it would have returned without that cycle.
- R9: `dout_o` changes only on an accepted pop. Between accepted pops it holds its value, including during pushes.
- R10: Every accepted pop leaves `full_o` at 0.
- R11: `full_o` and `empty_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| din_i | input | DATA_W | Word to push |
| dout_o | output | DATA_W | Data register: the word most recently popped |
| full_o | output | 1 | Stack holds DEPTH-1 words |
| empty_o | output | 1 | Stack holds no words |

## Verification
A push and a pop can be requested in the same cycle, and the block must then perform neither. The bench raises both requests together while the stack holds two words. It then checks that the flags and the data register are unchanged, and that the following pop returns the word pushed last before the clash. A second conflict occurs at the boundaries. A push against a full stack, or a pop against an empty one, must leave the flags and contents alone. The bench provokes both and judges them by the words that the subsequent pops return.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    // Operation actually performed in a cycle, after the flags and the
    // request clash have been taken into account.
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PUSH  = 2'd1,
        OP_POP   = 2'd2,
        OP_CLASH = 2'd3
    } stk_op_e;

endpackage

// File: rtl/rstk_decode.sv
module rstk_decode
    import rstk_pkg::*;
(
    input  logic    push_i,
    input  logic    pop_i,
    input  logic    full_i,
    input  logic    empty_i,
    output stk_op_e op_o
);

    always_comb begin
        op_o = OP_NONE;
        if (push_i && pop_i) begin
            op_o = OP_CLASH;
        end else if (push_i && !full_i) begin
            op_o = OP_PUSH;
        end else if (pop_i && !empty_i) begin
            op_o = OP_POP;
        end
    end

endmodule

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
    import rstk_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_op_e          op_i,
    output logic             full_o,
    output logic             empty_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_addr_o,
    output logic [PTR_W-1:0] rd_addr_o
);

    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] PTR_ZERO = '0;

    typedef struct packed {
        logic [PTR_W-1:0] sp;
        logic             full;
        logic             empty;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d   = ctl_q;
        wr_en_o = 1'b0;
        unique case (op_i)
            OP_PUSH: begin
                ctl_d.sp    = ctl_q.sp + PTR_W'(1);
                wr_en_o     = 1'b1;
                ctl_d.full  = (ctl_d.sp == PTR_LAST);
                ctl_d.empty = 1'b0;
            end
            OP_POP: begin
                ctl_d.sp    = ctl_q.sp - PTR_W'(1);
                ctl_d.empty = (ctl_d.sp == PTR_ZERO);
                ctl_d.full  = 1'b0;
            end
            default: begin
                ctl_d = ctl_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{sp: PTR_ZERO, full: 1'b0, empty: 1'b1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign full_o    = ctl_q.full;
    assign empty_o   = ctl_q.empty;
    assign wr_addr_o = ctl_q.sp + PTR_W'(1);
    assign rd_addr_o = ctl_q.sp;

    // R11: the two flags exclude each other
    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));

    // R5: empty flag agrees with the pointer at rest
    assert_empty_tracks_sp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o == (ctl_q.sp == PTR_ZERO));

    // R2: an accepted push leaves the stack non-empty
    assert_push_clears_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_PUSH) |=> !empty_o);

    // R10: an accepted pop leaves the stack not full
    assert_pop_clears_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_POP) |=> !full_o);

    // R6: no accepted push while full
    assert_no_push_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> (op_i != OP_PUSH));

    // R7: no accepted pop while empty
    assert_no_pop_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> (op_i != OP_POP));

    // R4: full is reached only through a push
    assert_full_from_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_o) |-> ($past(op_i) == OP_PUSH));

endmodule

// File: rtl/rstk_regfile.sv
module rstk_regfile #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/reg_stack.sv
module reg_stack
    import rstk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              full_o,
    output logic              empty_o
);

    localparam int PTR_W = $clog2(DEPTH);

    stk_op_e           op;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_addr;
    logic [PTR_W-1:0]  rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] dr_d, dr_q;

    rstk_decode u_decode (
        .push_i  (push_i),
        .pop_i   (pop_i),
        .full_i  (full_o),
        .empty_i (empty_o),
        .op_o    (op)
    );

    rstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .full_o    (full_o),
        .empty_o   (empty_o),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .rd_addr_o (rd_addr)
    );

    rstk_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_regfile (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (din_i),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    always_comb begin
        dr_d = dr_q;
        if (op == OP_POP) begin
            dr_d = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_q <= '0;
        end else begin
            dr_q <= dr_d;
        end
    end

    assign dout_o = dr_q;

    // R9: data register holds unless a pop is accepted
    assert_dr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_i && !push_i && !empty_o) |=> $stable(dout_o));

    // R8: simultaneous requests change nothing visible
    assert_clash_noop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> ($stable(full_o) && $stable(empty_o) && $stable(dout_o)));

endmodule

// File: tb/tb_reg_stack.sv
module tb_reg_stack;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int DEPTH      = 64;
    localparam int CAP        = DEPTH - 1;
    localparam int NVEC       = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_i = 1'b0;
    logic              pop_i = 1'b0;
    logic [DATA_W-1:0] din_i = '0;
    logic [DATA_W-1:0] dout_o;
    logic              full_o;
    logic              empty_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Vector fields: push, pop, din, expected dout, expected full, expected empty
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 8'hA1, 8'h00, 1'b0, 1'b0},  // R2 push
        {1'b1, 1'b0, 8'hB2, 8'h00, 1'b0, 1'b0},  // R2 push
        {1'b1, 1'b1, 8'hC3, 8'h00, 1'b0, 1'b0},  // R8 clash
        {1'b0, 1'b1, 8'h00, 8'hB2, 1'b0, 1'b0},  // R3/R8 pop top
        {1'b0, 1'b1, 8'h00, 8'hA1, 1'b0, 1'b1},  // R5 last pop
        {1'b0, 1'b1, 8'h00, 8'hA1, 1'b0, 1'b1},  // R7 pop on empty
        {1'b1, 1'b0, 8'h5A, 8'hA1, 1'b0, 1'b0},  // R9 push holds dout
        {1'b0, 1'b1, 8'h00, 8'h5A, 1'b0, 1'b1}   // R3 pop
    };

    reg_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push_i),
        .pop_i   (pop_i),
        .din_i   (din_i),
        .dout_o  (dout_o),
        .full_o  (full_o),
        .empty_o (empty_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // Drive on a falling edge, sample on the next falling edge (after one rising edge)
    task automatic step(input logic p, input logic q, input logic [DATA_W-1:0] d);
        @(negedge clk);
        push_i = p;
        pop_i  = q;
        din_i  = d;
        @(negedge clk);
        push_i = 1'b0;
        pop_i  = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        check("R1 empty", int'(empty_o), 1);
        check("R1 full", int'(full_o), 0);
        check("R1 dout", int'(dout_o), 0);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][19], VEC[i][18], VEC[i][17:10]);
            check($sformatf("vec%0d dout R3/R9", i), int'(dout_o), int'(VEC[i][9:2]));
            check($sformatf("vec%0d full R4", i), int'(full_o), int'(VEC[i][1]));
            check($sformatf("vec%0d empty R5", i), int'(empty_o), int'(VEC[i][0]));
        end

        // R1 again after activity
        do_reset();
        check("R1 dout after reset", int'(dout_o), 0);
        check("R1 empty after reset", int'(empty_o), 1);

        // R4: fill to capacity
        for (int i = 1; i <= CAP; i++) begin
            step(1'b1, 1'b0, DATA_W'(i));
            if (i == CAP - 1) check("R4 not full one short", int'(full_o), 0);
        end
        check("R4 full at capacity", int'(full_o), 1);
        check("R11 empty low when full", int'(empty_o), 0);

        // R6: push on full ignored
        step(1'b1, 1'b0, 8'hFF);
        check("R6 full stays", int'(full_o), 1);
        check("R9 dout during push", int'(dout_o), 0);

        // R8 at full: clash changes nothing
        step(1'b1, 1'b1, 8'hEE);
        check("R8 full kept", int'(full_o), 1);

        // Drain and check LIFO order
        for (int i = CAP; i >= 1; i--) begin
            step(1'b0, 1'b1, '0);
            check("R3 lifo order", int'(dout_o), i);
            if (i == CAP) check("R10 full cleared by pop", int'(full_o), 0);
            if (i == 2) check("R5 not empty with one left", int'(empty_o), 0);
        end
        check("R5 empty after drain", int'(empty_o), 1);

        // R7: pop on empty leaves dout and flags
        step(1'b0, 1'b1, '0);
        check("R7 dout kept", int'(dout_o), 1);
        check("R7 empty kept", int'(empty_o), 1);
        check("R7 full low", int'(full_o), 0);

        // R8 on empty: clash must not push
        step(1'b1, 1'b1, 8'h77);
        check("R8 empty kept", int'(empty_o), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule